// File: doc/BRIEF.md
# Multicycle Integer Multiply/Divide Unit

This block computes integer products and quotients beside a scalar integer pipeline. It does not block the pipeline while it works. A request is a one-cycle start strobe that carries an operation select (multiply or divide), an operand width (32 or 64 bits), a signedness flag and two 64-bit operands. The unit takes a fixed number of cycles that depends only on the operation and the width. When it finishes, it writes two dedicated 64-bit result registers, HI and LO, on the same clock edge.

The pipeline reads HI or LO through a single read port. The port has a request and a select. While a computation is in flight, a read request raises the stall output, so the pipeline can never pick up an out-of-date value. The stall drops on the first cycle the new results are visible. A new start that arrives during a computation abandons the old one and restarts the count.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy_o and stall_o are low, and both HI and LO read as zero.
- R2: Encodings are as follows. op_div_i=0 selects multiply and 1 selects divide. wide_i=1 selects 64-bit operands and 0 selects 32-bit. signed_i=1 treats operands as two's complement. A 32-bit operation uses only bits 31:0 of each operand. A 32-bit multiply writes the sign-extended upper 32 bits of the 64-bit product to HI and the sign-extended lower 32 bits to LO.
- R3: A 64-bit multiply writes bits 127:64 of the 128-bit product to HI and bits 63:0 to LO.
- R4: A divide writes the quotient, truncated toward zero, to LO. It writes the remainder to HI, with the sign of the dividend. A 32-bit divide sign-extends both 32-bit results. The signed most-negative value divided by -1 gives the most-negative value in LO and zero in HI.
- R5: Division by zero raises no error. LO becomes all ones. HI becomes the dividend, and for a 32-bit divide that is the sign extension of its low 32 bits.
- R6: After a start, busy_o is high for exactly 10 cycles (32-bit multiply), 12 (64-bit multiply), 42 (32-bit divide) or 74 (64-bit divide). HI and LO take their new values on the edge where busy_o falls.
- R7: stall_o is high exactly when rd_req_i is high and busy_o is high. A read that is held through a stall is released in the same cycle that busy_o falls. rd_data_o returns HI when rd_sel_hi_i=1 and LO when rd_sel_hi_i=0.
- R8: A start while busy_o is high abandons the earlier operation. The latency count restarts from the new start, and only the newest operation's results reach HI and LO.
- R9: HI and LO do not change at any time other than the completion edge of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| op_div_i | input | 1 | 0 multiply, 1 divide |
| wide_i | input | 1 | 1 for 64-bit operands, 0 for 32-bit |
| signed_i | input | 1 | 1 for signed operands |
| opa_i | input | 64 | Multiplicand or dividend |
| opb_i | input | 64 | Multiplier or divisor |
| rd_req_i | input | 1 | HI/LO read request from the pipeline |
| rd_sel_hi_i | input | 1 | 1 reads HI, 0 reads LO |
| busy_o | output | 1 | Operation in flight |
| stall_o | output | 1 | Read must wait |
| rd_data_o | output | 64 | Selected result register |

## Verification
The assertions assume three things about the inputs. rst_n is held low long enough to clear the counter. start_i is a clean strobe sampled at the clock edge. Operation fields are relevant only in the cycle start_i is high. The bench drives every input on the falling edge and holds start_i for exactly one cycle. Operands come from a fixed-seed random stream that is biased toward zero, all ones and the most-negative value. The bench also issues directed back-to-back starts, so the restart path is exercised inside a live busy window.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    KIND_MUL32 = 2'd0,
    KIND_MUL64 = 2'd1,
    KIND_DIV32 = 2'd2,
    KIND_DIV64 = 2'd3
  } op_kind_e;

  function automatic op_kind_e kind_of(input logic is_div, input logic wide);
    return op_kind_e'({is_div, wide});
  endfunction
endpackage

// File: rtl/muldiv_arith.sv
module muldiv_arith #(
  parameter int XLEN = 64
) (
  input  logic            is_div,
  input  logic            wide,
  input  logic            sgn,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res_hi,
  output logic [XLEN-1:0] res_lo
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0]   a_x, b_x, mag_a, mag_b;
  logic              neg_a, neg_b, neg_q;
  logic [2*XLEN-1:0] prod_mag, prod;
  logic [XLEN-1:0]   q_mag, r_mag, quo, rem;

  // operand widening: short operands take the sign only when signed
  always_comb begin
    if (wide) begin
      a_x = opa;
      b_x = opb;
    end else if (sgn) begin
      a_x = {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
      b_x = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
    end else begin
      a_x = {{HALF{1'b0}}, opa[HALF-1:0]};
      b_x = {{HALF{1'b0}}, opb[HALF-1:0]};
    end
    neg_a = sgn & a_x[XLEN-1];
    neg_b = sgn & b_x[XLEN-1];
    neg_q = neg_a ^ neg_b;
    mag_a = neg_a ? (~a_x + 1'b1) : a_x;
    mag_b = neg_b ? (~b_x + 1'b1) : b_x;
  end

  // sign-magnitude core shared by both operations
  always_comb begin
    prod_mag = {{XLEN{1'b0}}, mag_a} * {{XLEN{1'b0}}, mag_b};
    prod     = neg_q ? (~prod_mag + 1'b1) : prod_mag;
    if (b_x == '0) begin
      q_mag = '0;
      r_mag = '0;
      quo   = '1;
      rem   = a_x;
    end else begin
      q_mag = mag_a / mag_b;
      r_mag = mag_a % mag_b;
      quo   = neg_q ? (~q_mag + 1'b1) : q_mag;
      rem   = neg_a ? (~r_mag + 1'b1) : r_mag;
    end
  end

  always_comb begin
    unique case (muldiv_pkg::kind_of(is_div, wide))
      muldiv_pkg::KIND_MUL32: begin
        res_hi = {{HALF{prod[XLEN-1]}}, prod[XLEN-1:HALF]};
        res_lo = {{HALF{prod[HALF-1]}}, prod[HALF-1:0]};
      end
      muldiv_pkg::KIND_MUL64: begin
        res_hi = prod[2*XLEN-1:XLEN];
        res_lo = prod[XLEN-1:0];
      end
      muldiv_pkg::KIND_DIV32: begin
        res_hi = {{HALF{rem[HALF-1]}}, rem[HALF-1:0]};
        res_lo = {{HALF{quo[HALF-1]}}, quo[HALF-1:0]};
      end
      default: begin
        res_hi = rem;
        res_lo = quo;
      end
    endcase
  end
endmodule

// File: rtl/muldiv_timer.sv
module muldiv_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      cnt_d = load_val - 1'b1;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign done   = act_q & (cnt_q == '0) & ~start;

  // R6
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
  // R6
  count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q != '0 && !start) |=> (active && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int XLEN       = 64,
  parameter int LAT_MUL32  = 10,
  parameter int LAT_MUL64  = 12,
  parameter int LAT_DIV32  = 42,
  parameter int LAT_DIV64  = 74
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            op_div_i,
  input  logic            wide_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic            rd_req_i,
  input  logic            rd_sel_hi_i,
  output logic            busy_o,
  output logic            stall_o,
  output logic [XLEN-1:0] rd_data_o
);
  import muldiv_pkg::*;

  localparam int LAT_MAX = (LAT_DIV64 > LAT_DIV32) ? LAT_DIV64 : LAT_DIV32;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [XLEN-1:0]  calc_hi, calc_lo;
  logic [XLEN-1:0]  pend_hi_q, pend_lo_q, hi_q, lo_q;
  logic [CNT_W-1:0] lat_sel;
  logic             done;

  muldiv_arith #(.XLEN(XLEN)) u_arith (
    .is_div (op_div_i),
    .wide   (wide_i),
    .sgn    (signed_i),
    .opa    (opa_i),
    .opb    (opb_i),
    .res_hi (calc_hi),
    .res_lo (calc_lo)
  );

  always_comb begin
    unique case (kind_of(op_div_i, wide_i))
      KIND_MUL32: lat_sel = CNT_W'(LAT_MUL32);
      KIND_MUL64: lat_sel = CNT_W'(LAT_MUL64);
      KIND_DIV32: lat_sel = CNT_W'(LAT_DIV32);
      default:    lat_sel = CNT_W'(LAT_DIV64);
    endcase
  end

  muldiv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .load_val (lat_sel),
    .active   (busy_o),
    .done     (done)
  );

  // pending results, clock-enabled by the start strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi_q <= '0;
      pend_lo_q <= '0;
    end else if (start_i) begin
      pend_hi_q <= calc_hi;
      pend_lo_q <= calc_lo;
    end
  end

  // architectural HI/LO, clock-enabled by completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (done) begin
      hi_q <= pend_hi_q;
      lo_q <= pend_lo_q;
    end
  end

  assign stall_o   = rd_req_i & busy_o;
  assign rd_data_o = rd_sel_hi_i ? hi_q : lo_q;

  // R9
  hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(hi_q) && $stable(lo_q)));
  // R6
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> busy_o);
  // R7
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !stall_o);
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o && $stable(hi_q)));
endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, op_div_i = 1'b0, wide_i = 1'b0, signed_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        rd_req_i = 1'b0, rd_sel_hi_i = 1'b0;
  logic        busy_o, stall_o;
  logic [63:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] old_hi = '0, old_lo = '0;

  always #10 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
    .wide_i(wide_i), .signed_i(signed_i), .opa_i(opa_i), .opb_i(opb_i),
    .rd_req_i(rd_req_i), .rd_sel_hi_i(rd_sel_hi_i), .busy_o(busy_o),
    .stall_o(stall_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic model(input logic dv, wd, sg, input logic [63:0] a, b,
                       output logic [63:0] eh, el, output int lat);
    logic [63:0]  p64;
    logic [127:0] p128;
    longint       qa, qb;
    lat = dv ? (wd ? 74 : 42) : (wd ? 12 : 10);
    if (!dv) begin
      if (wd) begin
        if (sg) p128 = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
        else    p128 = {64'd0, a} * {64'd0, b};
        eh = p128[127:64]; el = p128[63:0];
      end else begin
        if (sg) p64 = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
        else    p64 = {32'd0, a[31:0]} * {32'd0, b[31:0]};
        eh = sx32(p64[63:32]); el = sx32(p64[31:0]);
      end
    end else if (wd) begin
      if (b == 64'd0) begin
        el = '1; eh = a;
      end else if (sg) begin
        if (a == 64'h8000_0000_0000_0000 && b == '1) begin
          el = a; eh = '0;
        end else begin
          qa = longint'(a); qb = longint'(b);
          el = 64'(qa / qb); eh = 64'(qa % qb);
        end
      end else begin
        el = a / b; eh = a % b;
      end
    end else begin
      if (b[31:0] == 32'd0) begin
        el = '1; eh = sx32(a[31:0]);
      end else begin
        if (sg) begin
          qa = longint'($signed(a[31:0])); qb = longint'($signed(b[31:0]));
        end else begin
          qa = longint'({32'd0, a[31:0]}); qb = longint'({32'd0, b[31:0]});
        end
        p64 = 64'(qa / qb); el = sx32(p64[31:0]);
        p64 = 64'(qa % qb); eh = sx32(p64[31:0]);
      end
    end
  endtask

  task automatic pulse(input logic dv, wd, sg, input logic [63:0] a, b);
    @(negedge clk);
    start_i = 1'b1; op_div_i = dv; wide_i = wd; signed_i = sg; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0; opa_i = $urandom(); opb_i = $urandom();
  endtask

  // follows the busy window of the newest start and checks the results
  task automatic finish(input logic dv, wd, sg, input logic [63:0] a, b, input string tag);
    logic [63:0] eh, el;
    int lat, n;
    model(dv, wd, sg, a, b, eh, el, lat);
    n = 0;
    rd_req_i = 1'b1;
    while (busy_o && n < 200) begin
      rd_sel_hi_i = n[0];
      #1;
      if (n == 0) chk(stall_o === 1'b1, "R7 stall during busy", {63'd0, stall_o}, 64'd1);
      if (n < 3 || n == lat - 1)
        chk(rd_data_o === (n[0] ? old_hi : old_lo), "R9 HI/LO held while busy",
            rd_data_o, n[0] ? old_hi : old_lo);
      n++;
      @(negedge clk);
    end
    chk(n == lat, "R6 latency", 64'(n), 64'(lat));
    #1;
    chk(stall_o === 1'b0, "R7 stall released", {63'd0, stall_o}, 64'd0);
    rd_sel_hi_i = 1'b1; #1;
    chk(rd_data_o === eh, {tag, " HI"}, rd_data_o, eh);
    rd_sel_hi_i = 1'b0; #1;
    chk(rd_data_o === el, {tag, " LO"}, rd_data_o, el);
    old_hi = eh; old_lo = el;
    rd_req_i = 1'b0;
  endtask

  task automatic run_op(input logic dv, wd, sg, input logic [63:0] a, b, input string tag);
    pulse(dv, wd, sg, a, b);
    finish(dv, wd, sg, a, b, tag);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 5))
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return {32'd0, $urandom()};
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  function automatic string tag_of(input logic dv, wd);
    if (!dv) return wd ? "R3 mul64" : "R2 mul32";
    return "R4 divide";
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4600));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_req_i = 1'b1; rd_sel_hi_i = 1'b1; #1;
    chk(busy_o === 1'b0, "R1 busy after reset", {63'd0, busy_o}, 64'd0);
    chk(stall_o === 1'b0, "R1 stall after reset", {63'd0, stall_o}, 64'd0);
    chk(rd_data_o === 64'd0, "R1 HI after reset", rd_data_o, 64'd0);
    rd_sel_hi_i = 1'b0; #1;
    chk(rd_data_o === 64'd0, "R1 LO after reset", rd_data_o, 64'd0);
    rd_req_i = 1'b0;

    // directed corners
    run_op(1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF, 64'd7, "R2 mul32 signed");
    run_op(1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R2 mul32 unsigned");
    run_op(1'b0, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R3 mul64 signed");
    run_op(1'b0, 1'b1, 1'b0, '1, '1, "R3 mul64 unsigned");
    run_op(1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, "R4 div64 negative dividend");
    run_op(1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, '1, "R4 div64 overflow");
    run_op(1'b1, 1'b0, 1'b1, 64'h8000_0000, 64'hFFFF_FFFF, "R4 div32 overflow");
    run_op(1'b1, 1'b0, 1'b0, 64'h1_FFFF_FFF0, 64'd3, "R4 div32 unsigned");
    run_op(1'b1, 1'b1, 1'b0, 64'd1234, 64'd0, "R5 div64 by zero");
    run_op(1'b1, 1'b0, 1'b1, 64'h0000_0000_8000_0005, 64'h7_0000_0000, "R5 div32 by zero");

    // R8: restart inside a live window, first with a longer op replaced by a shorter one
    pulse(1'b1, 1'b1, 1'b1, 64'd999, 64'd7);
    repeat (5) @(negedge clk);
    pulse(1'b0, 1'b0, 1'b1, 64'd6, 64'hFFFF_FFFD);
    finish(1'b0, 1'b0, 1'b1, 64'd6, 64'hFFFF_FFFD, "R8 restart mul32");
    pulse(1'b0, 1'b1, 1'b0, 64'd5, 64'd9);
    pulse(1'b1, 1'b0, 1'b1, 64'd100, 64'd7);
    finish(1'b1, 1'b0, 1'b1, 64'd100, 64'd7, "R8 back-to-back div32");

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      logic dv, wd, sg;
      logic [63:0] a, b;
      dv = 1'($urandom_range(0, 1));
      wd = 1'($urandom_range(0, 1));
      sg = 1'($urandom_range(0, 1));
      a = pick();
      b = pick();
      run_op(dv, wd, sg, a, b, tag_of(dv, wd));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule